// File: doc/BRIEF.md
# Page-Bounded Burst Splitter

This block takes one transfer request (a start address, a 16-bit programmed byte count, a count of bytes still owed by the peer, and a flag that marks a command-phase transfer) and hands out a series of bursts. Each burst has an address and a length, and no burst crosses a page boundary. Each burst starts where the previous one ended. The bursts go out over a valid/ready handshake, so a downstream mover can stall the block for any number of cycles.

When the last burst has been accepted, the block raises a one-cycle completion pulse. With the pulse it presents the residual count of owed bytes. A programmed count of zero stands for the largest possible transfer. In command phase the transfer is capped at a small fixed size, only the first burst is issued, and the residual is reported as zero. Address translation and the actual movement of data belong to neighbouring blocks.

Top module: `page_burst_splitter`

## Requirements
- R1: A programmed count of 0 is taken as 2^CNT_W bytes (65536 by default). With a page of 4096 bytes and a page-aligned start, this gives sixteen full-page bursts.
- R2: Outside command phase, the number of bytes moved is the smaller of the programmed count and the owed count.
- R3: In command phase, the transfer size is the smaller of the programmed count and CMD_CAP (32). Exactly one burst is issued, even if the page boundary cuts it short. The completion pulse then reports a residual of 0.
- R4: Let the end be the start plus the transfer size. While the current address and the end lie in different pages, the burst length is PAGE_BYTES minus the current offset within its page. Otherwise the burst length is the end minus the current address. No burst ever has length 0.
- R5: Every burst after the first starts at the previous burst's address plus its length.
- R6: The residual reported on completion is the owed count minus the sum of all burst lengths (data phase).
- R7: While seg_valid is high and seg_ready is low, seg_valid, seg_addr and seg_len hold their values.
- R8: done is high for exactly one cycle. That cycle is the one right after the clock edge that accepted the last burst. If the transfer size is 0, it is the cycle right after the request was accepted, and no burst is issued.
- R9: req_ready is high only while the block is idle. A request presented while the block is busy is ignored and does not disturb the transfer in progress.
- R10: After reset, req_ready is 1 and both seg_valid and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Start address |
| req_count | input | CNT_W | Programmed byte count; 0 means 2^CNT_W |
| req_owed | input | REM_W | Bytes still owed by the peer |
| req_cmd | input | 1 | Command-phase transfer |
| seg_valid | output | 1 | Burst offered |
| seg_ready | input | 1 | Burst taken |
| seg_addr | output | ADDR_W | Burst start address |
| seg_len | output | CNT_W+1 | Burst length in bytes |
| done | output | 1 | One-cycle completion pulse |
| done_owed | output | REM_W | Residual owed count, valid while done is high |

## Verification
Each result has a fixed cycle in which it is due:
- A request accepted at a clock edge shows its first burst in the very next cycle.
- A burst accepted at an edge is replaced by the next burst, or by the done pulse, in the cycle after that edge.
- done is low again one cycle later.

The bench drives inputs on the falling edge and reads outputs on the following falling edge. It advances its own model of the expected bursts only on the falling edges where it has just raised seg_ready. Done is therefore checked to arrive exactly one sample after the final acceptance. Stalled cycles are compared against the same expected burst, which is how holding is observed.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
   typedef enum logic [1:0] {
      PBS_IDLE = 2'd0,
      PBS_EMIT = 2'd1,
      PBS_FIN  = 2'd2
   } pbs_state_t;
endpackage

// File: rtl/pbs_len_clamp.sv
// Turns the programmed count into the effective transfer size.
module pbs_len_clamp #(
   parameter int CNT_W   = 16,
   parameter int REM_W   = 24,
   parameter int CMD_CAP = 32
) (
   input  logic [CNT_W-1:0] count,
   input  logic [REM_W-1:0] owed,
   input  logic             cmd,
   output logic [CNT_W:0]   eff_len
);
   localparam int LEN_W = CNT_W + 1;
   localparam int CW    = (LEN_W > REM_W) ? LEN_W : REM_W;

   logic [LEN_W-1:0] full_len;
   logic [CW-1:0]    a_w, lim_w;

   assign full_len = (count == '0) ? (LEN_W'(1) << CNT_W) : {1'b0, count};
   assign a_w      = CW'(full_len);

   if (CMD_CAP >= (1 << CNT_W)) begin : g_cap_never_binds
      assign lim_w = cmd ? a_w : CW'(owed);
   end else begin : g_cap_binds
      assign lim_w = cmd ? CW'(CMD_CAP) : CW'(owed);
   end

   assign eff_len = LEN_W'((a_w < lim_w) ? a_w : lim_w);
endmodule

// File: rtl/pbs_page_cut.sv
// Length of the burst starting at cur toward end_a, stopped at the page edge.
module pbs_page_cut #(
   parameter int AW1    = 33,
   parameter int LEN_W  = 17,
   parameter int PAGE_W = 12
) (
   input  logic [AW1-1:0]   cur,
   input  logic [AW1-1:0]   end_a,
   output logic [LEN_W-1:0] len
);
   logic [PAGE_W:0]  to_edge;
   logic [AW1-1:0]   span;
   logic             same_page;

   assign to_edge   = (PAGE_W+1)'(1 << PAGE_W) - {1'b0, cur[PAGE_W-1:0]};
   assign span      = end_a - cur;
   assign same_page = (cur[AW1-1:PAGE_W] == end_a[AW1-1:PAGE_W]);
   assign len       = same_page ? LEN_W'(span) : LEN_W'(to_edge);
endmodule

// File: rtl/pbs_seq.sv
// Request capture, burst stepping and completion.
module pbs_seq
   import pbs_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 17,
   parameter int REM_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  eff_len,
   input  logic [REM_W-1:0]  req_owed,
   input  logic              req_cmd,
   input  logic [LEN_W-1:0]  cut_len,
   input  logic              seg_ready,
   output logic              seg_valid,
   output logic [ADDR_W:0]   cur_q,
   output logic [ADDR_W:0]   end_q,
   output logic              done,
   output logic [REM_W-1:0]  done_owed
);
   localparam int AW1 = ADDR_W + 1;

   pbs_state_t       st_q;
   logic [LEN_W-1:0] left_q;
   logic [REM_W-1:0] owed_q;
   logic             cmd_q;
   logic             take_seg, last_seg;

   assign req_ready = (st_q == PBS_IDLE);
   assign seg_valid = (st_q == PBS_EMIT);
   assign done      = (st_q == PBS_FIN);
   assign done_owed = owed_q;
   assign take_seg  = seg_valid && seg_ready;
   assign last_seg  = cmd_q || (left_q == cut_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= PBS_IDLE;
         cur_q  <= '0;
         end_q  <= '0;
         left_q <= '0;
         owed_q <= '0;
         cmd_q  <= 1'b0;
      end else begin
         unique case (st_q)
            PBS_IDLE: if (req_valid) begin
               cur_q  <= {1'b0, req_addr};
               end_q  <= {1'b0, req_addr} + AW1'(eff_len);
               left_q <= eff_len;
               owed_q <= req_owed;
               cmd_q  <= req_cmd;
               st_q   <= (eff_len == '0) ? PBS_FIN : PBS_EMIT;
            end
            PBS_EMIT: if (take_seg) begin
               cur_q  <= cur_q + AW1'(cut_len);
               left_q <= left_q - cut_len;
               owed_q <= cmd_q ? '0 : owed_q - REM_W'(cut_len);
               if (last_seg) st_q <= PBS_FIN;
            end
            PBS_FIN:  st_q <= PBS_IDLE;
            default:  st_q <= PBS_IDLE;
         endcase
      end
   end

   // R3: a command-phase burst, once taken, is followed at once by done with zero residual
   a_r3_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
      (take_seg && cmd_q) |=> (done && done_owed == '0));
   // R8: done lasts one cycle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: no request is taken while bursts or completion are pending
   a_r9_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid || done) |-> !req_ready);
endmodule

// File: rtl/page_burst_splitter.sv
module page_burst_splitter #(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int REM_W      = 24,
   parameter int PAGE_BYTES = 4096,
   parameter int CMD_CAP    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CNT_W-1:0]  req_count,
   input  logic [REM_W-1:0]  req_owed,
   input  logic              req_cmd,
   output logic              seg_valid,
   input  logic              seg_ready,
   output logic [ADDR_W-1:0] seg_addr,
   output logic [CNT_W:0]    seg_len,
   output logic              done,
   output logic [REM_W-1:0]  done_owed
);
   localparam int LEN_W  = CNT_W + 1;
   localparam int AW1    = ADDR_W + 1;
   localparam int PAGE_W = $clog2(PAGE_BYTES);

   if (PAGE_BYTES != (1 << PAGE_W) || PAGE_W < 1) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (PAGE_W > CNT_W || PAGE_W >= ADDR_W) begin : g_bad_page_size
      $error("PAGE_BYTES must fit both the length and address widths");
   end
   if (CMD_CAP < 1) begin : g_bad_cap
      $error("CMD_CAP must be positive");
   end

   logic [LEN_W-1:0] eff_len, cut_len;
   logic [AW1-1:0]   cur_q, end_q;

   pbs_len_clamp #(.CNT_W(CNT_W), .REM_W(REM_W), .CMD_CAP(CMD_CAP)) u_clamp (
      .count(req_count), .owed(req_owed), .cmd(req_cmd), .eff_len(eff_len));

   pbs_page_cut #(.AW1(AW1), .LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_cut (
      .cur(cur_q), .end_a(end_q), .len(cut_len));

   pbs_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REM_W(REM_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .eff_len(eff_len), .req_owed(req_owed), .req_cmd(req_cmd),
      .cut_len(cut_len), .seg_ready(seg_ready), .seg_valid(seg_valid),
      .cur_q(cur_q), .end_q(end_q), .done(done), .done_owed(done_owed));

   assign seg_addr = cur_q[ADDR_W-1:0];
   assign seg_len  = cut_len;

   // R4: a burst is never empty and never leaves its page
   a_r4_in_page: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> (seg_len != '0 &&
                     (LEN_W+1)'(seg_addr[PAGE_W-1:0]) + (LEN_W+1)'(seg_len)
                        <= (LEN_W+1)'(PAGE_BYTES)));
   // R7: an offered burst holds until taken
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));
   // R5: the next burst starts where the taken one ended
   a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && seg_ready) |=>
         (!seg_valid || seg_addr == $past(seg_addr + ADDR_W'(seg_len))));
endmodule

// File: tb/sim_page_burst_splitter.sv
`timescale 1ns/1ps
module sim_page_burst_splitter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [15:0] req_count = '0;
   logic [23:0] req_owed = '0;
   logic        req_cmd = 1'b0;
   logic        seg_valid;
   logic        seg_ready = 1'b0;
   logic [31:0] seg_addr;
   logic [16:0] seg_len;
   logic        done;
   logic [23:0] done_owed;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   page_burst_splitter u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_count(req_count), .req_owed(req_owed), .req_cmd(req_cmd),
      .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
      .done(done), .done_owed(done_owed));

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
      end
   endtask

   // One transfer: model the bursts, drive the request, compare every output sample.
   task automatic run_case(input logic [31:0] a, input logic [15:0] c, input logic [23:0] r,
                           input logic cmd, input int stall, input bit poke, input string tag);
      longint eff, endv, cur, mc, len, exp_owed;
      int     n_exp, i, st;
      bit     prev_final, fin;
      eff = (c == 0) ? 65536 : longint'(c);
      if (cmd) eff = (eff < 32) ? eff : 32;
      else     eff = (eff < longint'(r)) ? eff : longint'(r);
      endv = longint'(a) + eff;
      n_exp = 0;
      mc = a;
      while (mc < endv && !(cmd && n_exp == 1)) begin
         len = ((mc >> 12) != (endv >> 12)) ? 4096 - (mc % 4096) : endv - mc;
         mc += len;
         n_exp++;
      end
      exp_owed = cmd ? 0 : longint'(r) - eff;

      @(negedge clk);
      req_addr = a; req_count = c; req_owed = r; req_cmd = cmd; req_valid = 1'b1;
      chk(req_ready == 1'b1, {tag, " R9 idle ready"}, req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      cur = a; i = 0; st = 0; fin = 0;
      prev_final = (n_exp == 0);
      for (int cyc = 0; cyc < 100000 && !fin; cyc++) begin
         if (done) begin
            chk(prev_final, {tag, " R8 done timing"}, i, n_exp);
            chk(i == n_exp, {tag, " burst count"}, i, n_exp);
            chk(done_owed == 24'(exp_owed), {tag, cmd ? " R3 residual" : " R6 residual"},
                done_owed, exp_owed);
            req_valid = 1'b0;
            seg_ready = 1'b0;
            fin = 1;
         end else begin
            if (prev_final) chk(0, {tag, " R8 done missing"}, 0, 1);
            prev_final = 0;
            if (seg_valid) begin
               chk(req_ready == 1'b0, {tag, " R9 busy refuse"}, req_ready, 0);
               if (poke) begin
                  req_valid = 1'b1; req_addr = 32'h00ABC000; req_count = 16'h0003;
                  req_cmd = ~cmd;
               end
               if (i >= n_exp) begin
                  chk(0, {tag, " R3 extra burst"}, seg_addr, 0);
                  seg_ready = 1'b1;
               end else begin
                  len = ((cur >> 12) != (endv >> 12)) ? 4096 - (cur % 4096) : endv - cur;
                  chk(seg_addr == 32'(cur), {tag, st > 0 ? " R7 addr hold" : " R5 addr"},
                      seg_addr, cur);
                  chk(seg_len == 17'(len), {tag, st > 0 ? " R7 len hold" : " R4 len"},
                      seg_len, len);
                  if (st < stall) begin
                     seg_ready = 1'b0; st++;
                  end else begin
                     seg_ready = 1'b1; st = 0; i++; cur += len;
                     prev_final = (i == n_exp);
                  end
               end
            end else begin
               seg_ready = 1'b0;
               chk(0, {tag, " R8 stall with nothing due"}, 0, 1);
            end
            @(negedge clk);
         end
      end
      chk(fin, {tag, " R8 completion seen"}, fin, 1);
      @(negedge clk);
      chk(done == 1'b0, {tag, " R8 single pulse"}, done, 0);
      chk(req_ready == 1'b1, {tag, " R9 idle again"}, req_ready, 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
      chk(seg_valid == 1'b0, "R10 seg_valid", seg_valid, 0);
      chk(done == 1'b0, "R10 done", done, 0);
   endtask

   task automatic t_one_page();    run_case(32'h0000_0100, 16'h0040, 24'h1000, 0, 0, 0, "R2 single"); endtask
   task automatic t_cross_stall(); run_case(32'h0000_0FF0, 16'h0100, 24'h1000, 0, 2, 0, "R4 cross"); endtask
   task automatic t_full_count();  run_case(32'h0001_0000, 16'h0000, 24'h020000, 0, 0, 0, "R1 zero count"); endtask
   task automatic t_owed_clamp();  run_case(32'h0000_2000, 16'h0800, 24'h000030, 0, 0, 0, "R2 owed clamp"); endtask
   task automatic t_owed_cross();  run_case(32'h0000_1FFC, 16'h2000, 24'h000009, 0, 1, 0, "R2 owed cross"); endtask
   task automatic t_cmd_cross();   run_case(32'h0000_0FF8, 16'h0100, 24'h000500, 1, 0, 0, "R3 cmd cut"); endtask
   task automatic t_cmd_small();   run_case(32'h0000_0040, 16'h0005, 24'h000000, 1, 1, 0, "R3 cmd small"); endtask
   task automatic t_nothing_owed();run_case(32'h0000_3000, 16'h0200, 24'h000000, 0, 0, 0, "R8 empty"); endtask
   task automatic t_busy_poke();   run_case(32'h0000_5F00, 16'h0300, 24'h004000, 0, 1, 1, "R9 poke"); endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_one_page();
      t_cross_stall();
      t_full_count();
      t_owed_clamp();
      t_owed_cross();
      t_cmd_cross();
      t_cmd_small();
      t_nothing_owed();
      t_busy_poke();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule